// File: doc/BRIEF.md
# Modem Control and Status Register Pair with Local Loopback

This block holds the two modem-facing registers of a 16550-style serial port. The first is a 5-bit control register that drives the DTR, RTS, OUT1 and OUT2 lines and selects local loopback. The second is a status byte that shows the four modem input lines together with four sticky change flags. Software writes the control register and reads either register through a plain select, read and write strobe interface. Each read returns its byte on `rdata` one cycle after the strobe.

Outside loopback, the status lines come from the external CTS, DSR, RI and DCD pins through a synchroniser of `SYNC_STAGES` flops. In loopback, the control bits feed the status lines crosswise and the external control outputs are held low. In both modes a change on a status line sets a flag and raises `ms_irq_o`, which stays high until software reads the status register. Serial data loopback and interrupt arbitration belong to neighbouring blocks.

There is no data stream in this block, so no valid/ready handshake is used. The strobes act once for each cycle in which they are high, and the block never stalls.

Top module: `mdm_ctl_stat`

## Requirements
- R1: After reset the control register, the status byte, `rdata`, `ms_irq_o` and the four control outputs are all zero.
- R2: A write with `reg_sel`=0 stores `wdata[4:0]` in the control register: bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 loopback. When loopback is off, `dtr_o`, `rts_o`, `out1_o` and `out2_o` follow bits 0 to 3 in the cycle after the write. A read with `reg_sel`=0 returns `{3'b000, control}`.
- R3: While control bit4 is set, `loop_o` is 1 and `dtr_o`, `rts_o`, `out1_o` and `out2_o` are 0.
- R4: In loopback, the status lines take these values one cycle after the control register does: CTS (status bit4) = RTS, DSR (bit5) = DTR, RI (bit6) = OUT1, DCD (bit7) = OUT2.
- R5: A change of CTS, DSR or DCD sets its flag (status bit0, bit1 or bit3 respectively) and sets `ms_irq_o`, in the same cycle that the new line value appears in the status byte.
- R6: Any change of RI sets `ms_irq_o`. Status bit2 is set only when RI goes from 1 to 0.
- R7: A read with `reg_sel`=1 returns the status byte as it was before the read, and then clears bits 0 to 3 and `ms_irq_o`. A change that lands in the same cycle as the read is kept.
- R8: A write with `reg_sel`=1 changes neither register.
- R9: Outside loopback, a change on an external pin appears in the status byte `SYNC_STAGES`+1 cycles after it is sampled, and sets the flags as in R5 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the status register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| cts_i | input | 1 | External clear-to-send pin |
| dsr_i | input | 1 | External data-set-ready pin |
| ri_i | input | 1 | External ring indicator pin |
| dcd_i | input | 1 | External carrier detect pin |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| loop_o | output | 1 | Loopback active |
| msr_o | output | 8 | Live status byte |
| ms_irq_o | output | 1 | Modem-status interrupt request |

## Verification
The bench first steps through loopback control patterns, each chosen to move one line group:
- a DTR/OUT1 rise, which tells the DSR flag apart from RI, since a rising RI sets no flag;
- an OUT1 fall, which gives the trailing-edge flag;
- an RTS/OUT2/DTR swap, which sets three flags at once.

A write followed at once by a status read checks that a change in the clear cycle is kept. Single-pin steps outside loopback measure the synchroniser latency. A stretch of random writes, reads and pin toggles then compares every output against a queue-based reference model on every clock.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int BYTE_W = 8;
  localparam int LINE_N = 4;
  localparam int CTL_W  = 5;
  // status line indices inside the 4-bit line vector
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } ctl_t;

  typedef enum logic {SEL_CTL = 1'b0, SEL_STAT = 1'b1} sel_e;
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mcs_chg_det.sv
module mcs_chg_det #(
  parameter int W      = 4,
  parameter int RI_IDX = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         clr,
  output logic [W-1:0] cur,
  output logic [W-1:0] dlt,
  output logic         irq
);
  logic [W-1:0] diff;
  logic [W-1:0] setv;

  assign diff = src ^ cur;

  for (genvar g = 0; g < W; g++) begin : g_flag
    if (g == RI_IDX) begin : g_fall
      assign setv[g] = cur[g] & ~src[g];
    end else begin : g_any
      assign setv[g] = diff[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur <= '0;
      dlt <= '0;
      irq <= 1'b0;
    end else begin
      cur <= src;
      dlt <= (clr ? '0 : dlt) | setv;
      irq <= (clr ? 1'b0 : irq) | (|diff);
    end

  AST_CTS_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlt[0]) |-> cur[0] != $past(cur[0])); // R5
  AST_RI_FLAG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlt[RI_IDX]) |-> ($past(cur[RI_IDX]) && !cur[RI_IDX])); // R6
  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != $past(cur)) |-> irq); // R5
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && cur == $past(cur)) |-> (dlt == '0 && !irq)); // R7
endmodule

// File: rtl/mdm_ctl_stat.sv
module mdm_ctl_stat
  import mcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              ri_i,
  input  logic              dcd_i,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              out1_o,
  output logic              out2_o,
  output logic              loop_o,
  output logic [BYTE_W-1:0] msr_o,
  output logic              ms_irq_o
);
  ctl_t              ctl_q;
  logic [LINE_N-1:0] pins, pins_s, lp_lines, src, cur, dlt;
  logic              clr, irq;
  logic              unused_hi;

  assign unused_hi = ^wdata[BYTE_W-1:CTL_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_q <= '0;
    else if (wr_en && sel_e'(reg_sel) == SEL_CTL) ctl_q <= ctl_t'(wdata[CTL_W-1:0]);

  assign pins = {dcd_i, ri_i, dsr_i, cts_i};

  mcs_sync #(.W(LINE_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(pins_s));

  // crosswise loopback mapping
  always_comb begin
    lp_lines        = '0;
    lp_lines[L_CTS] = ctl_q.rts;
    lp_lines[L_DSR] = ctl_q.dtr;
    lp_lines[L_RI]  = ctl_q.out1;
    lp_lines[L_DCD] = ctl_q.out2;
  end

  assign src = ctl_q.loop ? lp_lines : pins_s;
  assign clr = rd_en && sel_e'(reg_sel) == SEL_STAT;

  mcs_chg_det #(.W(LINE_N), .RI_IDX(L_RI)) u_det (
    .clk(clk), .rst_n(rst_n), .src(src), .clr(clr),
    .cur(cur), .dlt(dlt), .irq(irq));

  assign msr_o    = {cur, dlt};
  assign ms_irq_o = irq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else if (rd_en)
      rdata <= (sel_e'(reg_sel) == SEL_STAT) ? msr_o
                                             : {{(BYTE_W-CTL_W){1'b0}}, ctl_q};

  assign loop_o = ctl_q.loop;
  assign dtr_o  = ctl_q.dtr  & ~ctl_q.loop;
  assign rts_o  = ctl_q.rts  & ~ctl_q.loop;
  assign out1_o = ctl_q.out1 & ~ctl_q.loop;
  assign out2_o = ctl_q.out2 & ~ctl_q.loop;

  AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && !rd_en) |=> $stable(ctl_q)); // R8
  AST_LOOP_CTS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_q.loop) |-> msr_o[4] == $past(ctl_q.rts)); // R4
  AST_LOOP_DCD_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_q.loop) |-> msr_o[7] == $past(ctl_q.out2)); // R4
  AST_LOOP_OUTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    loop_o |-> !(dtr_o || rts_o || out1_o || out2_o)); // R3
endmodule

// File: tb/mdm_ctl_stat_tb.sv
module mdm_ctl_stat_tb;
  localparam int SYNC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, reg_sel = 0;
  logic [7:0] wdata = '0;
  logic cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
  logic [7:0] rdata, msr_o;
  logic dtr_o, rts_o, out1_o, out2_o, loop_o, ms_irq_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mdm_ctl_stat #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i),
    .dcd_i(dcd_i), .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
    .loop_o(loop_o), .msr_o(msr_o), .ms_irq_o(ms_irq_o));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [4:0] m_ctl;
  logic [3:0] m_cur, m_dlt;
  logic       m_irq;
  logic [7:0] m_rd;
  logic [3:0] m_pipe[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_cur = 0; m_dlt = 0; m_irq = 0; m_rd = 0;
      m_pipe = {};
      for (int i = 0; i < SYNC; i++) m_pipe.push_back(4'h0);
    end else begin
      logic [3:0] src, diff, setv;
      src = m_ctl[4] ? {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]} : m_pipe[SYNC-1];
      if (rd_en) m_rd = reg_sel ? {m_cur, m_dlt} : {3'b000, m_ctl};
      diff = src ^ m_cur;
      setv = {diff[3], m_cur[2] & ~src[2], diff[1], diff[0]};
      if (rd_en && reg_sel) begin m_dlt = 0; m_irq = 0; end
      m_dlt = m_dlt | setv;
      if (diff != 0) m_irq = 1;
      if (wr_en && !reg_sel) m_ctl = wdata[4:0];
      m_pipe.push_front({dcd_i, ri_i, dsr_i, cts_i});
      void'(m_pipe.pop_back());
      m_cur = src;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2/R3 outputs vs model", {loop_o, out2_o, out1_o, rts_o, dtr_o},
        m_ctl[4] ? 5'h10 : {1'b0, m_ctl[3:0]});
    chk("R4/R5/R6/R9 status vs model", msr_o, {m_cur, m_dlt});
    chk("R5/R6/R7 irq vs model", ms_irq_o, m_irq);
    chk("R7 rdata vs model", rdata, m_rd);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic sel, input logic [7:0] v);
    wr_en = 1; reg_sel = sel; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input logic sel);
    rd_en = 1; reg_sel = sel;
    @(negedge clk); rd_en = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(1);
    chk("R1 status", msr_o, 0); chk("R1 irq", ms_irq_o, 0); chk("R1 rdata", rdata, 0);
    chk("R1 outputs", {loop_o, out2_o, out1_o, rts_o, dtr_o}, 0);

    wr(0, 8'h0F);
    chk("R2 outputs", {loop_o, out2_o, out1_o, rts_o, dtr_o}, 5'h0F);
    rd(0); chk("R2 readback", rdata, 8'h0F);

    wr(0, 8'h15);
    chk("R3 outputs low in loop", {loop_o, out2_o, out1_o, rts_o, dtr_o}, 5'h10);
    chk("R4 not yet mapped", msr_o, 0);
    idle(1);
    chk("R4/R6 DSR+RI rise", msr_o, 8'h62); chk("R5 irq", ms_irq_o, 1);
    rd(1); chk("R7 read value", rdata, 8'h62);
    chk("R7 cleared", msr_o, 8'h60); chk("R7 irq cleared", ms_irq_o, 0);

    wr(0, 8'h11); idle(1);
    chk("R6 RI trailing edge", msr_o, 8'h24); chk("R6 irq", ms_irq_o, 1);
    rd(1); chk("R7 read value", rdata, 8'h24);

    wr(1, 8'hFF); idle(1);
    chk("R8 status unchanged", msr_o, 8'h20); chk("R8 irq unchanged", ms_irq_o, 0);
    rd(0); chk("R8 control unchanged", rdata, 8'h11);

    wr(0, 8'h1A); idle(1);
    chk("R5 three flags", msr_o, 8'h9B);
    rd(1); chk("R7 cleared", msr_o, 8'h90);

    wr(0, 8'h00); idle(1);
    chk("R5 leave loop", msr_o, 8'h09);
    rd(1);

    wr(0, 8'h12); rd(1);
    chk("R7 read before change", rdata, 8'h00);
    chk("R7 change kept", msr_o, 8'h11); chk("R7 irq kept", ms_irq_o, 1);
    rd(1); wr(0, 8'h00); idle(1); rd(1);
    chk("R7 cleared after drop", msr_o, 8'h00);

    cts_i = 1; idle(2);
    chk("R9 latency not yet", msr_o, 8'h00);
    idle(1);
    chk("R9 pin CTS seen", msr_o, 8'h11);
    ri_i = 1; idle(3); ri_i = 0; idle(3);
    chk("R6/R9 pin RI fall", msr_o, 8'h15);
    rd(1);

    for (int i = 0; i < 400; i++) begin
      wr_en = ($urandom % 4) == 0; rd_en = ($urandom % 3) == 0;
      reg_sel = $urandom; wdata = $urandom;
      {cts_i, dsr_i, ri_i, dcd_i} = ($urandom % 5 == 0) ? 4'($urandom) : {cts_i, dsr_i, ri_i, dcd_i};
      @(negedge clk);
    end
    wr_en = 0; rd_en = 0; idle(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule